// File: doc/BRIEF.md
# Condition-Code Compare Unit

This unit evaluates the register-compare instructions of a small processor core and stores the resulting condition bit. A 16-bit instruction word names the operation and picks the operands. The first operand always comes from a register. The second comes either from a register or from a 3-bit immediate held in the instruction. Each register operand is taken from the data-register group or the pointer-register group. The register file reads both candidate values for each operand at the indices in the instruction, and the unit chooses between them.

On every cycle with the valid strobe high, the unit subtracts the second operand from the first. From that difference it derives equality, signed ordering and unsigned ordering. It registers the condition bit and three status flags: zero, negative and carry. Compares that involve the accumulator pair are recognised but not evaluated here. They raise an unsupported flag and leave the condition state untouched, so that another unit can handle them.

Top module: `ccCompareUnit`

## Requirements
- R1: Instruction fields are: bit 10 selects the immediate as second operand, bits 9:7 give the operation, bit 6 selects the pointer group (1) over the data group (0) for register operands, bits 5:3 give the second-operand index or immediate, and bits 2:0 give the first-operand index. Bits 15:11 are not decoded.
- R2: Operation 0 sets CC to 1 exactly when the two operands are equal.
- R3: Operation 1 sets CC when the first operand is less than the second as two's-complement numbers. Overflow of the subtraction is taken into account, so that for example 0x80000000 < 1 and not 0x7FFFFFFF < 0xFFFFFFFF.
- R4: Operation 2 sets CC when the first operand is signed less than or equal to the second.
- R5: Operation 3 sets CC for unsigned less than, and operation 4 sets it for unsigned less than or equal.
- R6: With bit 10 set, the 3-bit immediate is sign-extended for operations 0 to 2 (7 reads as -1) and zero-extended for operations 3 and 4 (7 reads as 7).
- R7: A supported compare sets the zero flag when first minus second is 0. It sets the negative flag from bit 31 of that difference. It sets the carry flag when first is below second as unsigned numbers.
- R8: Operations 5 to 7, whatever the select bits, set the unsupported flag and leave CC and all three status flags unchanged. A supported valid compare clears the unsupported flag.
- R9: Results appear on the clock edge that samples the valid strobe high. With the strobe low, all outputs hold, whatever the other inputs do.
- R10: After reset, CC, the three status flags and the unsupported flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | Compare instruction present this cycle |
| instWord | input | 16 | Compare instruction word |
| firstData | input | 32 | Data register at index bits 2:0 |
| firstPtr | input | 32 | Pointer register at index bits 2:0 |
| secondData | input | 32 | Data register at index bits 5:3 |
| secondPtr | input | 32 | Pointer register at index bits 5:3 |
| ccOut | output | 1 | Registered condition bit |
| zeroFlag | output | 1 | Difference was zero |
| negFlag | output | 1 | Difference bit 31 |
| carryFlag | output | 1 | First below second, unsigned |
| unsupported | output | 1 | Last valid instruction was an accumulator compare |

## Verification
The bench builds the unit with its default operand width of 32 bits. This puts the real sign-boundary values within reach: 0x80000000, 0x7FFFFFFF and all-ones. Signed and unsigned ordering disagree at these values, and the overflow term of the signed compare decides the result. With the 3-bit immediate field, the bench can reach both extension paths with the value 7, which reads as -1 or as 7 depending on the operation.

// File: rtl/ccCmpPkg.sv
package ccCmpPkg;
  localparam int INST_W = 16;
  localparam int IMM_W  = 3;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_EQ    = 3'd0,
    OP_LTS   = 3'd1,
    OP_LES   = 3'd2,
    OP_LTU   = 3'd3,
    OP_LEU   = 3'd4,
    OP_ACCEQ = 3'd5,
    OP_ACCLT = 3'd6,
    OP_ACCLE = 3'd7
  } cmpOp_e;

  typedef struct packed {
    logic             loadFlags;
    logic             useImm;
    logic             usePtr;
    logic             signExt;
    cmpOp_e           op;
    logic [IMM_W-1:0] immField;
  } cmpCtrl_t;
endpackage

// File: rtl/ccCmpCtrl.sv
module ccCmpCtrl
  import ccCmpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  output cmpCtrl_t          ctrl,
  output logic              unsupported
);
  localparam int IMM_BIT = 10;
  localparam int OP_LSB  = 7;
  localparam int PTR_BIT = 6;
  localparam int Y_LSB   = 3;

  cmpOp_e opDec;
  logic   isAccCmp;

  always_comb begin
    opDec         = cmpOp_e'(instWord[OP_LSB +: OP_W]);
    isAccCmp      = (opDec == OP_ACCEQ) || (opDec == OP_ACCLT) || (opDec == OP_ACCLE);
    ctrl.op       = opDec;
    ctrl.useImm   = instWord[IMM_BIT];
    ctrl.usePtr   = instWord[PTR_BIT];
    ctrl.immField = instWord[Y_LSB +: IMM_W];
    ctrl.signExt  = (opDec == OP_EQ) || (opDec == OP_LTS) || (opDec == OP_LES);
    ctrl.loadFlags = instValid && !isAccCmp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          unsupported <= 1'b0;
    else if (instValid) unsupported <= isAccCmp;
  end

  // R8
  unsup_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[OP_LSB +: OP_W] >= 3'd5) |=> unsupported);
  // R8
  unsup_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instWord[OP_LSB +: OP_W] < 3'd5) |=> !unsupported);
  // R9
  unsup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> $stable(unsupported));
endmodule

// File: rtl/ccCmpDatapath.sv
module ccCmpDatapath
  import ccCmpPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpCtrl_t          ctrl,
  input  logic [DATA_W-1:0] firstData,
  input  logic [DATA_W-1:0] firstPtr,
  input  logic [DATA_W-1:0] secondData,
  input  logic [DATA_W-1:0] secondPtr,
  output logic              ccOut,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              carryFlag
);
  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] opA, opB, immExt, diff;
  logic [DATA_W:0]   wideDiff;
  logic zeroN, negN, carryN, ovf, ltSigned, ccN;

  always_comb begin
    immExt   = ctrl.signExt ? {{EXT_W{ctrl.immField[IMM_W-1]}}, ctrl.immField}
                            : {{EXT_W{1'b0}}, ctrl.immField};
    opA      = ctrl.usePtr ? firstPtr : firstData;
    opB      = ctrl.useImm ? immExt : (ctrl.usePtr ? secondPtr : secondData);
    wideDiff = {1'b0, opA} - {1'b0, opB};
    diff     = wideDiff[MSB:0];
    zeroN    = (diff == '0);
    negN     = diff[MSB];
    carryN   = wideDiff[DATA_W];
    ovf      = (opA[MSB] ^ opB[MSB]) & (negN ^ opA[MSB]);
    ltSigned = negN ^ ovf;
    unique case (ctrl.op)
      OP_EQ:   ccN = zeroN;
      OP_LTS:  ccN = ltSigned;
      OP_LES:  ccN = ltSigned | zeroN;
      OP_LTU:  ccN = carryN;
      OP_LEU:  ccN = carryN | zeroN;
      default: ccN = ccOut;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccOut     <= 1'b0;
      zeroFlag  <= 1'b0;
      negFlag   <= 1'b0;
      carryFlag <= 1'b0;
    end else if (ctrl.loadFlags) begin
      ccOut     <= ccN;
      zeroFlag  <= zeroN;
      negFlag   <= negN;
      carryFlag <= carryN;
    end
  end

  // R2
  eq_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && ctrl.op == OP_EQ) |=> (ccOut == zeroFlag));
  // R5
  ltu_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && ctrl.op == OP_LTU) |=> (ccOut == carryFlag));
  // R5
  leu_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadFlags && ctrl.op == OP_LEU) |=> (ccOut == (carryFlag | zeroFlag)));
  // R7
  zero_carry_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroFlag |-> !carryFlag);
  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadFlags |=> $stable({ccOut, zeroFlag, negFlag, carryFlag}));
endmodule

// File: rtl/ccCompareUnit.sv
module ccCompareUnit
  import ccCmpPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [DATA_W-1:0] firstData,
  input  logic [DATA_W-1:0] firstPtr,
  input  logic [DATA_W-1:0] secondData,
  input  logic [DATA_W-1:0] secondPtr,
  output logic              ccOut,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              carryFlag,
  output logic              unsupported
);
  cmpCtrl_t ctrl;

  ccCmpCtrl uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .ctrl(ctrl), .unsupported(unsupported)
  );

  ccCmpDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .firstData(firstData), .firstPtr(firstPtr),
    .secondData(secondData), .secondPtr(secondPtr),
    .ccOut(ccOut), .zeroFlag(zeroFlag), .negFlag(negFlag), .carryFlag(carryFlag)
  );
endmodule

// File: tb/tb_ccCompareUnit.sv
module tb_ccCompareUnit;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic [15:0]   instWord = '0;
  logic [DW-1:0] firstData = '0, firstPtr = '0, secondData = '0, secondPtr = '0;
  logic          ccOut, zeroFlag, negFlag, carryFlag, unsupported;

  int total = 0;
  int failed = 0;

  always #5 clk = ~clk;

  ccCompareUnit #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .firstData(firstData), .firstPtr(firstPtr),
    .secondData(secondData), .secondPtr(secondPtr),
    .ccOut(ccOut), .zeroFlag(zeroFlag), .negFlag(negFlag),
    .carryFlag(carryFlag), .unsupported(unsupported)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input logic [4:0] top, input logic imm,
      input logic [2:0] op, input logic ptr, input logic [2:0] y, input logic [2:0] x);
    return {top, imm, op, ptr, y, x};
  endfunction

  task automatic issue(input logic [15:0] w, input logic [DW-1:0] fd, input logic [DW-1:0] fp,
                       input logic [DW-1:0] sd, input logic [DW-1:0] sp);
    @(negedge clk);
    instWord = w; firstData = fd; firstPtr = fp; secondData = sd; secondPtr = sp;
    instValid = 1'b1;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  // issue a supported compare and check CC and all flags against a model
  task automatic cmpCase(input string req, input logic [15:0] w, input logic [DW-1:0] fd,
      input logic [DW-1:0] fp, input logic [DW-1:0] sd, input logic [DW-1:0] sp);
    logic [DW-1:0] a, b, d;
    logic [2:0] op;
    logic expCc;
    op = w[9:7];
    a  = w[6] ? fp : fd;
    if (w[10]) b = (op <= 3'd2) ? {{(DW-3){w[5]}}, w[5:3]} : {{(DW-3){1'b0}}, w[5:3]};
    else       b = w[6] ? sp : sd;
    d = a - b;
    case (op)
      3'd0: expCc = (a == b);
      3'd1: expCc = ($signed(a) < $signed(b));
      3'd2: expCc = ($signed(a) <= $signed(b));
      3'd3: expCc = (a < b);
      default: expCc = (a <= b);
    endcase
    issue(w, fd, fp, sd, sp);
    chk({req, " cc"}, DW'(ccOut), DW'(expCc));
    chk({req, " R7 zero"}, DW'(zeroFlag), DW'(a == b));
    chk({req, " R7 neg"}, DW'(negFlag), DW'(d[DW-1]));
    chk({req, " R7 carry"}, DW'(carryFlag), DW'(a < b));
    chk({req, " R8 unsup clear"}, DW'(unsupported), '0);
  endtask

  task automatic testReset();
    chk("R10 cc", DW'(ccOut), '0);
    chk("R10 flags", DW'({zeroFlag, negFlag, carryFlag}), '0);
    chk("R10 unsup", DW'(unsupported), '0);
  endtask

  task automatic testEqual();
    cmpCase("R2 eq same", mkWord(5'b00001, 0, 0, 0, 1, 2), 32'h1234, 0, 32'h1234, 0);
    cmpCase("R2 eq diff", mkWord(5'b00001, 0, 0, 0, 1, 2), 32'h1234, 0, 32'h1235, 0);
  endtask

  task automatic testSigned();
    cmpCase("R3 min<1", mkWord(5'b00001, 0, 1, 0, 0, 0), 32'h80000000, 0, 32'h1, 0);
    cmpCase("R3 max<-1", mkWord(5'b00001, 0, 1, 0, 0, 0), 32'h7FFFFFFF, 0, 32'hFFFFFFFF, 0);
    cmpCase("R3 -1<max", mkWord(5'b00001, 0, 1, 0, 0, 0), 32'hFFFFFFFF, 0, 32'h7FFFFFFF, 0);
    cmpCase("R4 le equal", mkWord(5'b00001, 0, 2, 0, 0, 0), 32'h80000000, 0, 32'h80000000, 0);
    cmpCase("R4 le greater", mkWord(5'b00001, 0, 2, 0, 0, 0), 32'h5, 0, 32'hFFFFFFF0, 0);
  endtask

  task automatic testUnsigned();
    cmpCase("R5 ltu", mkWord(5'b00001, 0, 3, 0, 0, 0), 32'h7FFFFFFF, 0, 32'h80000000, 0);
    cmpCase("R5 ltu eq", mkWord(5'b00001, 0, 3, 0, 0, 0), 32'h40, 0, 32'h40, 0);
    cmpCase("R5 leu eq", mkWord(5'b00001, 0, 4, 0, 0, 0), 32'h40, 0, 32'h40, 0);
    cmpCase("R5 leu gt", mkWord(5'b00001, 0, 4, 0, 0, 0), 32'hFFFFFFFF, 0, 32'h0, 0);
  endtask

  task automatic testImmediate();
    // imm 7: -1 for signed ops, 7 for unsigned ops
    cmpCase("R6 eq -1", mkWord(5'b00001, 1, 0, 0, 7, 0), 32'hFFFFFFFF, 0, 32'h0, 0);
    cmpCase("R6 lts -1", mkWord(5'b00001, 1, 1, 0, 7, 0), 32'h3, 0, 32'h0, 0);
    cmpCase("R6 ltu 7", mkWord(5'b00001, 1, 3, 0, 7, 0), 32'h3, 0, 32'h0, 0);
    cmpCase("R6 leu 7", mkWord(5'b00001, 1, 4, 1, 7, 0), 32'h0, 32'h7, 32'h0, 0);
  endtask

  task automatic testSelect();
    cmpCase("R1 ptr group", mkWord(5'b00001, 0, 0, 1, 0, 0), 32'h1, 32'h99, 32'h2, 32'h99);
    cmpCase("R1 data group", mkWord(5'b00001, 0, 3, 0, 0, 0), 32'h1, 32'h99, 32'h2, 32'h0);
    cmpCase("R1 upper bits", mkWord(5'b11111, 0, 0, 0, 0, 0), 32'h7, 0, 32'h7, 0);
  endtask

  task automatic testUnsupported();
    // establish cc=1, zero=1 then send accumulator compares
    cmpCase("R8 setup", mkWord(5'b00001, 0, 0, 0, 0, 0), 32'h5, 0, 32'h5, 0);
    issue(mkWord(5'b00001, 0, 5, 0, 0, 0), 32'h1, 0, 32'h9, 0);
    chk("R8 unsup op5", DW'(unsupported), 1);
    chk("R8 cc kept", DW'(ccOut), 1);
    chk("R8 flags kept", DW'({zeroFlag, negFlag, carryFlag}), DW'(3'b100));
    issue(mkWord(5'b00001, 1, 7, 1, 3, 0), 32'h1, 32'h1, 32'h9, 32'h9);
    chk("R8 unsup op7 sel", DW'(unsupported), 1);
    chk("R8 state kept", DW'({ccOut, zeroFlag, negFlag, carryFlag}), DW'(4'b1100));
    cmpCase("R8 clear", mkWord(5'b00001, 0, 3, 0, 0, 0), 32'h1, 0, 32'h2, 0);
  endtask

  task automatic testHold();
    cmpCase("R9 setup", mkWord(5'b00001, 0, 1, 0, 0, 0), 32'hFFFFFFFF, 0, 32'h1, 0);
    @(negedge clk);
    instWord = mkWord(5'b00001, 0, 0, 0, 0, 0);
    firstData = 32'h3; secondData = 32'h3;
    repeat (3) @(negedge clk);
    chk("R9 hold state", DW'({ccOut, zeroFlag, negFlag, carryFlag, unsupported}), DW'(5'b10100));
  endtask

  initial begin
    #(200000 * 10);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testEqual();
    testSigned();
    testUnsigned();
    testImmediate();
    testSelect();
    testUnsupported();
    testHold();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule